// File: doc/BRIEF.md
# Nibble-Wide Channel Program Loader

This block fetches the divider settings of a frequency synthesiser from a small external memory, one 4-bit word at a time. It counts down the reference clock to a slow program clock, drives a 3-bit word address and a memory-enable, and captures eight nibbles. It then assembles them into a 10-bit main count (M), a 7-bit swallow count (A) and an 11-bit reference count (R). All three values are handed to the counters together, in a transfer slot after the last word, and marked by a single-cycle strobe.

A read can start in three ways. An edge of either polarity on the program-enable input starts one read. Holding that input low makes the reads repeat back to back. After power-good rises, a fixed delay is counted and a read then starts on its own. The address and memory-enable pins are modelled as a value plus a drive-enable, so that the surrounding pads can release them while the block is idle. The R value is meant for a reference divider that accepts 3 to 2047 and divides by twice that number. This block passes R through unchanged.

Top module: `nibble_prog_sequencer`

## Requirements
- R1: During and after a synchronous active-low reset, `mem_en_drive`, `addr_oe` and `xfer_stb` are 0 and `m_val`, `a_val` and `r_val` are 0.
- R2: With the block idle, a change of the synchronised `prog_en` level (falling or rising) raises `mem_en_drive` and `addr_oe` at the third rising clock edge after the input changes. A steady `prog_en` level never starts a read from idle.
- R3: A read is 16 program slots of 64 reference cycles each. Slots 0-3 are settling time, slots 4-11 fetch words 0-7 with `addr` equal to the word index, and `addr` is 0 in every other slot of the read.
- R4: Each word is sampled 32 cycles into its slot. With word k held on `din`: word 0 bits 3:2 are M[1:0]; words 1 and 2 are M[5:2] and M[9:6]; word 3 is A[3:0]; word 4 bits 2:0 are A[6:4]; words 5 and 6 are R[3:0] and R[7:4]; word 7 bits 2:0 are R[10:8].
- R5: Word 0 bits 1:0, word 4 bit 3 and word 7 bit 3 have no effect on `m_val`, `a_val` or `r_val`.
- R6: `xfer_stb` is a one-cycle pulse 768 cycles after the read starts, at the opening of slot 12. `m_val`, `a_val` and `r_val` change only on that cycle, all together.
- R7: A single read holds `mem_en_drive` and `addr_oe` for exactly 1024 cycles, then releases both.
- R8: A `prog_en` edge that arrives while a read is running is ignored: no extra read and no extra strobe.
- R9: If the synchronised `prog_en` is low when a read ends, the next read starts on the following cycle. Strobes then come every 1024 cycles and `mem_en_drive` stays asserted throughout. Raising `prog_en` lets the current read finish and ends the sequence.
- R10: Once the synchronised `pwr_good` is high, a read starts automatically 53248 cycles later, with `mem_en_drive` visible at the 53250th rising edge after `pwr_good` rises. No automatic read occurs while `pwr_good` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prog_en | input | 1 | Program enable: an edge starts one read, a held low repeats reads |
| pwr_good | input | 1 | Power-good level that arms the automatic read |
| din | input | 4 | Nibble returned by the external memory |
| addr | output | 3 | Word address to the memory |
| addr_oe | output | 1 | Drive enable for `addr` (0 releases the bus) |
| mem_en_drive | output | 1 | 1 pulls the memory enable low, 0 leaves it floating |
| m_val | output | 10 | Main counter value |
| a_val | output | 7 | Swallow counter value |
| r_val | output | 11 | Reference counter value |
| xfer_stb | output | 1 | One-cycle strobe when new values are transferred |

## Verification
Every result has a fixed cycle count after its stimulus. The bench counts falling clock edges from the edge on which it changes `prog_en` or `pwr_good`. It expects the enables at edge 3 (53250 for power-up), the strobe and new values at edge 771, and the release at edge 1027. In repeat mode it expects strobes at 771 and 1795. The bench samples the outputs only on falling edges, half a cycle after the register that drives them has switched. It therefore compares each observed edge number with the exact expected number, not with a window. Mid-slot address checks use the same count, taken relative to the first asserted cycle.

// File: rtl/nps_pkg.sv
`timescale 1ns/1ps
// Shared widths for the nibble program loader.
// Assumes a fixed eight-word frame of 4-bit words.
package nps_pkg;
    localparam int NIB_W  = 4;
    localparam int ADDR_W = 3;
    localparam int WORDS  = 8;
    localparam int M_W    = 10;
    localparam int A_W    = 7;
    localparam int R_W    = 11;
    typedef logic [NIB_W-1:0] nibble_t;
endpackage

// File: rtl/nps_sync_edge.sv
`timescale 1ns/1ps
// Brings an asynchronous level into the clock domain and flags each change.
// Assumes the input is slow compared with clk; the edge flag is held off
// until the chain has been refilled after reset, so reset gives no false edge.
module nps_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic lvl,
    output logic chg
);
    logic [STAGES:0] chain_q;
    logic [STAGES:0] fill_q;

    // Shift the level and a validity marker through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            fill_q  <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], d_in};
            fill_q  <= {fill_q[STAGES-1:0], 1'b1};
        end
    end

    assign lvl = chain_q[STAGES-1];
    assign chg = fill_q[STAGES] && (chain_q[STAGES] ^ chain_q[STAGES-1]);
endmodule

// File: rtl/nps_por_timer.sv
`timescale 1ns/1ps
// Counts a fixed delay after power-good and then fires one start pulse.
// Assumes power-good may drop at any time; a drop clears and re-arms the timer.
module nps_por_timer #(
    parameter int POR_CYCLES = 53248
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    output logic fire
);
    localparam int CW = $clog2(POR_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(POR_CYCLES - 1);

    logic          pg_meta, pg_sync, done_q;
    logic [CW-1:0] cnt_q;

    // Two-flop synchroniser for power-good.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_meta <= 1'b0;
            pg_sync <= 1'b0;
        end else begin
            pg_meta <= pwr_good;
            pg_sync <= pg_meta;
        end
    end

    // Delay counter; stops once it has fired until power-good drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !pg_sync) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == CNT_LAST) done_q <= 1'b1;
            else                   cnt_q  <= cnt_q + CW'(1);
        end
    end

    assign fire = pg_sync && !done_q && (cnt_q == CNT_LAST);
endmodule

// File: rtl/nps_frame_ctrl.sv
`timescale 1ns/1ps
// Read sequencer: divides clk into program slots and walks one read frame.
// Assumes SETTLE_SLOTS + WORDS + 1 <= FRAME_SLOTS; starts are ignored while busy.
module nps_frame_ctrl
    import nps_pkg::*;
#(
    parameter int CLK_DIV      = 64,
    parameter int SETTLE_SLOTS = 4,
    parameter int FRAME_SLOTS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              hold_low,
    output logic              busy,
    output logic              word_slot,
    output logic              sample_pulse,
    output logic              xfer_pulse,
    output logic [ADDR_W-1:0] word_idx
);
    localparam int PW = $clog2(CLK_DIV);
    localparam int SW = $clog2(FRAME_SLOTS);
    localparam logic [PW-1:0] PRE_LAST   = PW'(CLK_DIV - 1);
    localparam logic [PW-1:0] PRE_MID    = PW'(CLK_DIV / 2 - 1);
    localparam logic [SW-1:0] SLOT_LAST  = SW'(FRAME_SLOTS - 1);
    localparam logic [SW-1:0] SLOT_W0    = SW'(SETTLE_SLOTS);
    localparam logic [SW-1:0] SLOT_WEND  = SW'(SETTLE_SLOTS + WORDS);
    localparam logic [SW-1:0] SLOT_WLAST = SW'(SETTLE_SLOTS + WORDS - 1);

    logic          busy_q;
    logic [PW-1:0] pre_q;
    logic [SW-1:0] slot_q;

    // Frame state: idle, or prescaler and slot counter running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pre_q  <= '0;
            slot_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                pre_q  <= '0;
                slot_q <= '0;
            end
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            if (slot_q == SLOT_LAST) begin
                slot_q <= '0;
                busy_q <= hold_low;
            end else begin
                slot_q <= slot_q + SW'(1);
            end
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end

    // Slot decode for the address phase, mid-slot sample and transfer point.
    always_comb begin
        busy         = busy_q;
        word_slot    = busy_q && (slot_q >= SLOT_W0) && (slot_q < SLOT_WEND);
        word_idx     = ADDR_W'(slot_q - SLOT_W0);
        sample_pulse = word_slot && (pre_q == PRE_MID);
        xfer_pulse   = busy_q && (slot_q == SLOT_WLAST) && (pre_q == PRE_LAST);
    end
endmodule

// File: rtl/nps_word_store.sv
`timescale 1ns/1ps
// Scatters sampled nibbles into shadow fields and moves them out together.
// Assumes the fixed eight-word bit map; unmapped nibble bits are dropped.
module nps_word_store
    import nps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [ADDR_W-1:0] idx,
    input  nibble_t           din,
    input  logic              load,
    output logic [M_W-1:0]    m_val,
    output logic [A_W-1:0]    a_val,
    output logic [R_W-1:0]    r_val,
    output logic              stb
);
    logic [M_W-1:0] sh_m;
    logic [A_W-1:0] sh_a;
    logic [R_W-1:0] sh_r;

    // Shadow capture: each word index owns a fixed slice of one field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_m <= '0;
            sh_a <= '0;
            sh_r <= '0;
        end else if (sample) begin
            case (idx)
                3'd0: sh_m[1:0]  <= din[3:2];
                3'd1: sh_m[5:2]  <= din;
                3'd2: sh_m[9:6]  <= din;
                3'd3: sh_a[3:0]  <= din;
                3'd4: sh_a[6:4]  <= din[2:0];
                3'd5: sh_r[3:0]  <= din;
                3'd6: sh_r[7:4]  <= din;
                default: sh_r[10:8] <= din[2:0];
            endcase
        end
    end

    // Output stage: all three values and the strobe update on one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_val <= '0;
            a_val <= '0;
            r_val <= '0;
            stb   <= 1'b0;
        end else begin
            stb <= load;
            if (load) begin
                m_val <= sh_m;
                a_val <= sh_a;
                r_val <= sh_r;
            end
        end
    end
endmodule

// File: rtl/nibble_prog_sequencer.sv
`timescale 1ns/1ps
// Top of the nibble program loader: start sources, frame sequencer and store.
// Assumes din is valid from the address change to the mid-slot sample point.
module nibble_prog_sequencer
    import nps_pkg::*;
#(
    parameter int CLK_DIV      = 64,
    parameter int SETTLE_SLOTS = 4,
    parameter int FRAME_SLOTS  = 16,
    parameter int POR_CYCLES   = 53248,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              pwr_good,
    input  logic [NIB_W-1:0]  din,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_oe,
    output logic              mem_en_drive,
    output logic [M_W-1:0]    m_val,
    output logic [A_W-1:0]    a_val,
    output logic [R_W-1:0]    r_val,
    output logic              xfer_stb
);
    logic              pe_lvl, pe_chg, por_fire;
    logic              busy, word_slot, sample_pulse, xfer_pulse;
    logic [ADDR_W-1:0] word_idx;

    nps_sync_edge #(.STAGES(SYNC_STAGES)) u_pe_sync (
        .clk(clk), .rst_n(rst_n), .d_in(prog_en), .lvl(pe_lvl), .chg(pe_chg)
    );

    nps_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .fire(por_fire)
    );

    nps_frame_ctrl #(
        .CLK_DIV(CLK_DIV), .SETTLE_SLOTS(SETTLE_SLOTS), .FRAME_SLOTS(FRAME_SLOTS)
    ) u_frame (
        .clk(clk), .rst_n(rst_n), .start(pe_chg || por_fire), .hold_low(!pe_lvl),
        .busy(busy), .word_slot(word_slot), .sample_pulse(sample_pulse),
        .xfer_pulse(xfer_pulse), .word_idx(word_idx)
    );

    nps_word_store u_store (
        .clk(clk), .rst_n(rst_n), .sample(sample_pulse), .idx(word_idx),
        .din(din), .load(xfer_pulse), .m_val(m_val), .a_val(a_val),
        .r_val(r_val), .stb(xfer_stb)
    );

    // Pad controls: bus and enable are driven only while a read is running.
    always_comb begin
        addr_oe      = busy;
        mem_en_drive = busy;
        addr         = word_slot ? word_idx : '0;
    end
endmodule

// File: rtl/nibble_prog_sequencer_chk.sv
`timescale 1ns/1ps
// Protocol checks on the loader's ports, bound into every instance.
module nibble_prog_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_en_drive,
    input logic        addr_oe,
    input logic [2:0]  addr,
    input logic        xfer_stb,
    input logic [9:0]  m_val,
    input logic [6:0]  a_val,
    input logic [10:0] r_val
);
    // R6
    stb_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stb |=> !xfer_stb);
    // R6
    stb_inside_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stb |-> mem_en_drive);
    // R6
    values_move_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(m_val) || !$stable(a_val) || !$stable(r_val)) |-> xfer_stb);
    // R7
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_en_drive) |-> !addr_oe);
    // R3
    idle_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_oe |-> (addr == 3'd0));
    // R2
    no_stb_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_en_drive) |-> !xfer_stb);
endmodule

bind nibble_prog_sequencer nibble_prog_sequencer_chk i_nps_chk (
    .clk(clk), .rst_n(rst_n), .mem_en_drive(mem_en_drive), .addr_oe(addr_oe),
    .addr(addr), .xfer_stb(xfer_stb), .m_val(m_val), .a_val(a_val), .r_val(r_val)
);

// File: tb/test_nibble_prog_sequencer.sv
`timescale 1ns/1ps
module test_nibble_prog_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_en = 1'b1;
    logic        pwr_good = 1'b0;
    logic [3:0]  din = 4'hF;
    logic [2:0]  addr;
    logic        addr_oe, mem_en_drive, xfer_stb;
    logic [9:0]  m_val;
    logic [6:0]  a_val;
    logic [10:0] r_val;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [31:0] img, img2;
    int obs_first, obs_last, obs_gap, obs_oe_err, obs_addr_err, obs_stbn;
    int obs_sk [2];
    logic [9:0]  obs_m [2];
    logic [6:0]  obs_a [2];
    logic [10:0] obs_r [2];

    always #10 clk = ~clk;

    nibble_prog_sequencer i_nibble_prog_sequencer (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .pwr_good(pwr_good),
        .din(din), .addr(addr), .addr_oe(addr_oe), .mem_en_drive(mem_en_drive),
        .m_val(m_val), .a_val(a_val), .r_val(r_val), .xfer_stb(xfer_stb)
    );

    // Memory model: word k of the image sits in img[4k+3:4k]; pull-ups when released.
    initial forever begin
        @(negedge clk);
        din = addr_oe ? img[{addr, 2'b00} +: 4] : 4'hF;
    end

    function automatic logic [9:0] exp_m(input logic [31:0] w);
        return {w[11:8], w[7:4], w[3:2]};
    endfunction
    function automatic logic [6:0] exp_a(input logic [31:0] w);
        return {w[18:16], w[15:12]};
    endfunction
    function automatic logic [10:0] exp_r(input logic [31:0] w);
        return {w[30:28], w[27:24], w[23:20]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Watch the ports for span falling edges; optionally flip prog_en and swap the image.
    task automatic watch(input int span, input int flip_at, input logic flip_lvl,
                         input int swap_at);
        obs_first = 0; obs_last = 0; obs_gap = 0; obs_oe_err = 0;
        obs_addr_err = 0; obs_stbn = 0;
        for (int k = 1; k <= span; k++) begin
            @(negedge clk);
            if (mem_en_drive) begin
                if (obs_first == 0) obs_first = k;
                obs_last = k;
            end else if (obs_first != 0 && obs_last == k - 1) begin
                obs_gap = obs_gap + 0;
            end
            if (addr_oe !== mem_en_drive) obs_oe_err++;
            if (mem_en_drive && obs_first != 0) begin
                int c, s, ea;
                c = (k - obs_first) % 1024;
                if (c % 64 == 32) begin
                    s  = c / 64;
                    ea = (s >= 4 && s < 12) ? s - 4 : 0;
                    if (addr !== 3'(ea)) obs_addr_err++;
                end
            end
            if (xfer_stb) begin
                if (obs_stbn < 2) begin
                    obs_sk[obs_stbn] = k;
                    obs_m[obs_stbn]  = m_val;
                    obs_a[obs_stbn]  = a_val;
                    obs_r[obs_stbn]  = r_val;
                end
                obs_stbn++;
            end
            if (k == flip_at) prog_en = flip_lvl;
            if (k == swap_at) img = img2;
        end
    endtask

    // Count edges inside [obs_first, obs_last] where the enable was low.
    task automatic count_gaps(input int span_first, input int span_last);
        obs_gap = (obs_last - obs_first + 1) - (span_last - span_first + 1);
    endtask

    task automatic check_vals(input int i, input logic [31:0] w, input string req);
        chk(obs_m[i] == exp_m(w), req, "M value", obs_m[i], exp_m(w));
        chk(obs_a[i] == exp_a(w), req, "A value", obs_a[i], exp_a(w));
        chk(obs_r[i] == exp_r(w), req, "R value", obs_r[i], exp_r(w));
    endtask

    task automatic check_reset(input string tag);
        chk(!mem_en_drive && !addr_oe && !xfer_stb, "R1", {tag, " enables"},
            {mem_en_drive, addr_oe, xfer_stb}, 0);
        chk(m_val == 0 && a_val == 0 && r_val == 0, "R1", {tag, " values"},
            m_val + a_val + r_val, 0);
    endtask

    initial begin
        int on_cnt;
        void'($urandom(32'd2718));
        img = 32'h0; img2 = 32'h0;
        repeat (5) @(negedge clk);
        check_reset("after reset");
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // Single reads from a high idle level: random images, then directed corners.
        for (int t = 0; t < 7; t++) begin
            if (t < 5)       img = $urandom();
            else if (t == 5) img = 32'hFFFF_FFFF;
            else             img = 32'h8008_0003;   // only the unmapped bits set (R5)
            @(negedge clk);
            prog_en = 1'b0;
            watch(2200, 10, 1'b1, 0);
            chk(obs_first == 3, "R2", "enable edge after falling start", obs_first, 3);
            chk(obs_sk[0] == 771 && obs_stbn >= 1, "R6", "strobe edge", obs_sk[0], 771);
            chk(obs_stbn == 1, "R8", "strobes for one read with mid-read edge", obs_stbn, 1);
            chk(obs_last == 1026, "R7", "last enabled edge", obs_last, 1026);
            chk(obs_oe_err == 0, "R7", "addr_oe vs enable mismatches", obs_oe_err, 0);
            chk(obs_addr_err == 0, "R3", "mid-slot address errors", obs_addr_err, 0);
            check_vals(0, img, (t == 6) ? "R5" : "R4");
        end

        // Repeat mode: held low, image changed between reads, released during read two.
        img  = $urandom();
        img2 = $urandom();
        begin
            logic [31:0] first_img;
            first_img = img;
            @(negedge clk);
            prog_en = 1'b0;
            watch(3000, 1900, 1'b1, 1000);
            chk(obs_stbn == 2, "R9", "strobe count in repeat mode", obs_stbn, 2);
            chk(obs_sk[0] == 771, "R9", "first repeat strobe edge", obs_sk[0], 771);
            chk(obs_sk[1] == 1795, "R9", "second repeat strobe edge", obs_sk[1], 1795);
            chk(obs_last == 2050, "R9", "last enabled edge after release", obs_last, 2050);
            check_vals(0, first_img, "R4");
            check_vals(1, img2, "R9");
            chk(obs_addr_err == 0, "R3", "repeat mode address errors", obs_addr_err, 0);
        end

        // Rising edge start: reset with prog_en low, idle, then raise it.
        prog_en = 1'b0;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check_reset("second reset");
        rst_n = 1'b1;
        on_cnt = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (mem_en_drive) on_cnt++;
        end
        chk(on_cnt == 0, "R2", "enabled edges with steady low level", on_cnt, 0);
        img = $urandom();
        prog_en = 1'b1;
        watch(2200, 0, 1'b1, 0);
        chk(obs_first == 3, "R2", "enable edge after rising start", obs_first, 3);
        chk(obs_sk[0] == 771 && obs_stbn == 1, "R6", "strobe edge, rising start", obs_sk[0], 771);
        chk(obs_last == 1026, "R7", "last enabled edge, rising start", obs_last, 1026);
        check_vals(0, img, "R4");

        // Power-up read: pwr_good has been low so far; raise it and time the delay.
        img = $urandom();
        @(negedge clk);
        pwr_good = 1'b1;
        watch(54400, 0, 1'b1, 0);
        chk(obs_first == 53250, "R10", "enable edge after power-good", obs_first, 53250);
        chk(obs_sk[0] == 54018 && obs_stbn == 1, "R10", "power-up strobe edge", obs_sk[0], 54018);
        chk(obs_last == 54273, "R10", "power-up last enabled edge", obs_last, 54273);
        check_vals(0, img, "R10");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check and still reports.
    initial begin
        #(20 * 190000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule